// File: doc/BRIEF.md
# Downstream Port Secondary Reset Sequencer

This block runs one downstream port of a packet switch through a reset of its secondary bus that software starts. Software sets a control bit for the port. The block then does three things in turn. First, if the link was up at that moment, it asks the link layer to keep sending training sets that carry the hot-reset flag. Second, it issues a one-cycle strobe that drops every packet from this port still sitting in the switch queues. Third, it holds the port in reset until software clears the bit. After one resume cycle the port returns to normal work.

For as long as the reset lasts, the block sorts each packet into one of three routes:

- Type 0 configuration accesses aimed at the port's own bridge function are completed locally.
- Anything bound for the secondary side is rejected as an unsupported request.
- All other traffic is forwarded untouched, so the upstream port, the sibling ports and the management sideband carry on as before.

Outside reset, every packet is forwarded. The routing answer is combinational from the packet class and the current state.

Top module: `dsp_sbr_seq`

## Requirements
- R1: After reset and while idle, `hot_req` and `flush_stb` are low and `verdict` is 00 (forward) for every `pkt_kind`.
- R2: When `sbr_ctrl` is high in an idle cycle and `link_up` is high, `hot_req` is high from the next cycle. The training phase lasts `HOTRST_CYCLES` cycles, and the flush phase starts after it.
- R3: When `sbr_ctrl` is high in an idle cycle and `link_up` is low, the training phase is skipped and `hot_req` stays low for the whole sequence, whatever `link_up` does later.
- R4: `flush_stb` is high for exactly one cycle per sequence, in the first cycle of the flush phase. That cycle follows the training phase, or comes one cycle after the start when the link was down.
- R5: The flush phase lasts at least two cycles. It ends after the first cycle past the strobe in which `queue_empty` is high, and the hold phase follows.
- R6: When the training phase was taken, `hot_req` stays high through the flush and hold phases. It goes low in the cycle after the hold phase sees `sbr_ctrl` low.
- R7: While a sequence is active (training, flush, hold or resume), `pkt_kind` 00 (Type 0 configuration to this bridge) gives `verdict` 01 (complete locally).
- R8: While a sequence is active, `pkt_kind` 01 (bound for the secondary side) gives `verdict` 10 (unsupported request).
- R9: `pkt_kind` 10 and 11 (traffic not owned by this port's secondary side) always give `verdict` 00.
- R10: The hold phase continues while `sbr_ctrl` is high, even if it was cleared earlier in the sequence. After the hold phase there is one resume cycle, then idle. Setting `sbr_ctrl` again while a sequence is active starts no second sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sbr_ctrl | input | 1 | Software secondary-bus-reset control bit for this port |
| link_up | input | 1 | Link layer reports the link is up |
| queue_empty | input | 1 | No packets from this port remain queued |
| pkt_kind | input | 2 | Class of the packet being routed (00 cfg to self, 01 secondary, 10/11 other) |
| hot_req | output | 1 | Request to send training sets with the hot-reset flag |
| flush_stb | output | 1 | One-cycle discard strobe for queued packets |
| verdict | output | 2 | 00 forward, 01 complete locally, 10 unsupported request |

## Verification
The hardest case to reach is a long flush: a queue that stays busy while the control bit has already been cleared or set again, so that the exit from hold depends on the bit's value only when the hold phase is reached. Directed sequences hold `queue_empty` low for many cycles and drop `sbr_ctrl` during training. Random stimulus toggles the bit and the link rarely but flips queue status often, which produces long flush phases and mid-sequence link changes. A cycle-level reference model in the bench predicts all three outputs on every cycle.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_HOTTX  = 3'd1,
        S_FLUSH  = 3'd2,
        S_HOLD   = 3'd3,
        S_RESUME = 3'd4
    } sbr_state_t;

    typedef enum logic [1:0] {
        PK_CFG_SELF  = 2'd0,
        PK_SECONDARY = 2'd1,
        PK_OTHER     = 2'd2,
        PK_SPARE     = 2'd3
    } pkt_kind_t;

    typedef enum logic [1:0] {
        V_FWD   = 2'd0,
        V_LOCAL = 2'd1,
        V_UR    = 2'd2
    } verdict_t;

    // Port is inside a reset sequence in every state but idle.
    function automatic logic seq_active(sbr_state_t s);
        return s != S_IDLE;
    endfunction

    // States during which the hot-reset request may be shown.
    function automatic logic hot_window(sbr_state_t s);
        return (s == S_HOTTX) || (s == S_FLUSH) || (s == S_HOLD);
    endfunction

endpackage

// File: rtl/sbr_flush_gen.sv
module sbr_flush_gen
    import sbr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  sbr_state_t state,
    output logic       flush_stb
);
    logic in_flush_q;

    always_ff @(posedge clk) begin
        if (rst) in_flush_q <= 1'b0;
        else     in_flush_q <= (state == S_FLUSH);
    end

    // High only on the first cycle spent in the flush phase.
    assign flush_stb = (state == S_FLUSH) && !in_flush_q;
endmodule

// File: rtl/sbr_fsm.sv
module sbr_fsm
    import sbr_pkg::*;
#(
    parameter int HOTRST_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sbr_ctrl,
    input  logic       link_up,
    input  logic       queue_empty,
    input  logic       flush_stb,
    output sbr_state_t state,
    output logic       hot_sel
);
    localparam int CNT_W = (HOTRST_CYCLES > 1) ? $clog2(HOTRST_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOTRST_CYCLES - 1);

    sbr_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             hot_q, hot_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        hot_d   = hot_q;
        unique case (state_q)
            S_IDLE: begin
                hot_d = 1'b0;
                if (sbr_ctrl) begin
                    hot_d   = link_up;
                    cnt_d   = '0;
                    state_d = link_up ? S_HOTTX : S_FLUSH;
                end
            end
            S_HOTTX: begin
                cnt_d = cnt_q + 1'b1;
                if (cnt_q == CNT_LAST) state_d = S_FLUSH;
            end
            S_FLUSH: begin
                // The strobe cycle never counts as drained.
                if (!flush_stb && queue_empty) state_d = S_HOLD;
            end
            S_HOLD: begin
                if (!sbr_ctrl) state_d = S_RESUME;
            end
            S_RESUME: begin
                hot_d   = 1'b0;
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            hot_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            hot_q   <= hot_d;
        end
    end

    assign state   = state_q;
    assign hot_sel = hot_q;
endmodule

// File: rtl/sbr_verdict.sv
module sbr_verdict
    import sbr_pkg::*;
(
    input  logic      active,
    input  pkt_kind_t kind,
    output verdict_t  verdict
);
    always_comb begin
        verdict = V_FWD;
        if (active) begin
            case (kind)
                PK_CFG_SELF:  verdict = V_LOCAL;
                PK_SECONDARY: verdict = V_UR;
                default:      verdict = V_FWD;
            endcase
        end
    end
endmodule

// File: rtl/dsp_sbr_seq.sv
module dsp_sbr_seq
    import sbr_pkg::*;
#(
    parameter int HOTRST_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sbr_ctrl,
    input  logic       link_up,
    input  logic       queue_empty,
    input  logic [1:0] pkt_kind,
    output logic       hot_req,
    output logic       flush_stb,
    output logic [1:0] verdict
);
    sbr_state_t state_q;
    logic       hot_sel;
    verdict_t   verdict_e;

    sbr_fsm #(.HOTRST_CYCLES(HOTRST_CYCLES)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .sbr_ctrl    (sbr_ctrl),
        .link_up     (link_up),
        .queue_empty (queue_empty),
        .flush_stb   (flush_stb),
        .state       (state_q),
        .hot_sel     (hot_sel)
    );

    sbr_flush_gen u_flush (
        .clk       (clk),
        .rst       (rst),
        .state     (state_q),
        .flush_stb (flush_stb)
    );

    sbr_verdict u_verdict (
        .active  (seq_active(state_q)),
        .kind    (pkt_kind_t'(pkt_kind)),
        .verdict (verdict_e)
    );

    assign hot_req = hot_sel && hot_window(state_q);
    assign verdict = verdict_e;
endmodule

// File: rtl/sbr_seq_chk.sv
module sbr_seq_chk
    import sbr_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       sbr_ctrl,
    input logic       link_up,
    input logic       queue_empty,
    input logic [1:0] pkt_kind,
    input logic       hot_req,
    input logic       flush_stb,
    input logic [1:0] verdict,
    input sbr_state_t state
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE) |-> (!hot_req && !flush_stb && verdict == 2'd0));

    a_r2_hot_on_link_up: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && sbr_ctrl && link_up) |=> hot_req);

    a_r3_no_hot_link_down: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && sbr_ctrl && !link_up) |=> !hot_req);

    a_r4_strobe_single: assert property (@(posedge clk) disable iff (rst)
        flush_stb |=> !flush_stb);

    a_r5_flush_waits: assert property (@(posedge clk) disable iff (rst)
        (state == S_FLUSH && !queue_empty) |=> (state == S_FLUSH));

    a_r6_hot_kept_in_hold: assert property (@(posedge clk) disable iff (rst)
        (state == S_HOLD && hot_req && sbr_ctrl) |=> hot_req);

    a_r7_cfg_local: assert property (@(posedge clk) disable iff (rst)
        (state != S_IDLE && pkt_kind == 2'd0) |-> (verdict == 2'd1));

    a_r8_secondary_ur: assert property (@(posedge clk) disable iff (rst)
        (state != S_IDLE && pkt_kind == 2'd1) |-> (verdict == 2'd2));

    a_r9_other_fwd: assert property (@(posedge clk) disable iff (rst)
        pkt_kind[1] |-> (verdict == 2'd0));

    a_r10_hold_until_clear: assert property (@(posedge clk) disable iff (rst)
        (state == S_HOLD && sbr_ctrl) |=> (state == S_HOLD));
endmodule

bind dsp_sbr_seq sbr_seq_chk u_sbr_seq_chk (
    .clk         (clk),
    .rst         (rst),
    .sbr_ctrl    (sbr_ctrl),
    .link_up     (link_up),
    .queue_empty (queue_empty),
    .pkt_kind    (pkt_kind),
    .hot_req     (hot_req),
    .flush_stb   (flush_stb),
    .verdict     (verdict),
    .state       (state_q)
);

// File: tb/tb_dsp_sbr_seq.sv
`timescale 1ns/1ps
module tb_dsp_sbr_seq;
    localparam int N_HOT = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sbr_ctrl = 1'b0;
    logic       link_up = 1'b0;
    logic       queue_empty = 1'b1;
    logic [1:0] pkt_kind = 2'd0;
    logic       hot_req, flush_stb;
    logic [1:0] verdict;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference model: 0 idle, 1 training, 2 flush, 3 hold, 4 resume
    int m_st = 0;
    bit m_hot = 1'b0;
    int m_cnt = 0;
    int m_fcyc = 0;

    always #10 clk = ~clk;

    dsp_sbr_seq #(.HOTRST_CYCLES(N_HOT)) dut (
        .clk(clk), .rst(rst), .sbr_ctrl(sbr_ctrl), .link_up(link_up),
        .queue_empty(queue_empty), .pkt_kind(pkt_kind),
        .hot_req(hot_req), .flush_stb(flush_stb), .verdict(verdict)
    );

    function automatic logic exp_hot();
        return m_hot && (m_st == 1 || m_st == 2 || m_st == 3);
    endfunction

    function automatic logic exp_flush();
        return (m_st == 2) && (m_fcyc == 0);
    endfunction

    function automatic logic [1:0] exp_verdict(logic [1:0] k);
        if (m_st == 0 || k[1]) return 2'd0;
        return (k == 2'd0) ? 2'd1 : 2'd2;
    endfunction

    task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s t=%0t actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    task automatic model_step();
        if (rst) begin
            m_st = 0; m_hot = 0; m_cnt = 0; m_fcyc = 0;
            return;
        end
        case (m_st)
            0: if (sbr_ctrl) begin
                   m_hot = link_up; m_cnt = 0; m_fcyc = 0;
                   m_st = link_up ? 1 : 2;
               end
            1: begin
                   if (m_cnt == N_HOT - 1) begin m_st = 2; m_fcyc = 0; end
                   m_cnt++;
               end
            2: begin
                   if (m_fcyc > 0 && queue_empty) m_st = 3;
                   m_fcyc++;
               end
            3: if (!sbr_ctrl) m_st = 4;
            default: begin m_st = 0; m_hot = 0; end
        endcase
    endtask

    task automatic cyc(bit r, bit s, bit l, bit e, logic [1:0] k);
        @(negedge clk);
        rst = r; sbr_ctrl = s; link_up = l; queue_empty = e; pkt_kind = k;
        #1;
        if (m_st == 0) begin
            chk("R1 hot_req", {1'b0, hot_req}, {1'b0, exp_hot()});
            chk("R1 flush_stb", {1'b0, flush_stb}, {1'b0, exp_flush()});
        end else begin
            chk(m_hot ? "R6 hot_req" : "R3 hot_req", {1'b0, hot_req}, {1'b0, exp_hot()});
            chk(m_fcyc == 0 ? "R4 flush_stb" : "R5 flush_stb",
                {1'b0, flush_stb}, {1'b0, exp_flush()});
        end
        chk(k[1] ? "R9 verdict" : (m_st == 0 ? "R1 verdict" :
            (k == 2'd0 ? "R7 verdict" : "R8 verdict")), verdict, exp_verdict(k));
        model_step();
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        // Reset state (R1)
        for (int i = 0; i < 3; i++) cyc(1, 0, 1, 1, 2'(i));
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, 1, 2'(i));

        // R2, R4, R5, R6: link up, busy queue, hold, then clear
        cyc(0, 1, 1, 0, 2'd1);
        for (int i = 0; i < 12; i++) cyc(0, 1, 1, 0, 2'(i));
        for (int i = 0; i < 6; i++) cyc(0, 1, 0, 1, 2'(i));
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, 1, 2'(i));

        // R3: link down at start, link rises during the sequence
        cyc(0, 1, 0, 1, 2'd0);
        for (int i = 0; i < 8; i++) cyc(0, 1, 1, 1, 2'(i));
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, 1, 2'(i));

        // R10: bit dropped during training, re-set during flush
        cyc(0, 1, 1, 0, 2'd1);
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 2'd1);
        for (int i = 0; i < 5; i++) cyc(0, 1, 1, 0, 2'd0);
        for (int i = 0; i < 6; i++) cyc(0, 0, 1, 1, 2'd1);
        // R5: queue empty already on the strobe cycle
        cyc(0, 1, 0, 1, 2'd1);
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 2'd1);

        // Random phase with a fixed seed
        begin
            bit s = 0, l = 1;
            int seed_dummy = $urandom(32'h5EB1_2024);
            for (int i = 0; i < 6000; i++) begin
                if ($urandom_range(39) == 0) s = ~s;
                if ($urandom_range(19) == 0) l = ~l;
                cyc(($urandom_range(499) == 0), s, l,
                    ($urandom_range(2) == 0), 2'($urandom_range(3)));
            end
            if (seed_dummy == 0) s = 0;
        end
        summary();
    end
endmodule